// File: doc/BRIEF.md
# Stride-2 Fused Convolution Feature Engine

This block turns a raster stream of grayscale Q15 pixels, one pixel per clock at most, into one subsampled feature map. It does not run a 5x5 convolution and then a 2x2 average as two passes. Instead it applies one 6x6 kernel that is stepped two pixels across and two rows down. The taps of that kernel are prepared offline from the small kernel, so they already contain the averaging weights and the pooling scale. Each window sum is added to a bias, then rounded and saturated to Q15. The result goes through a hyperbolic-tangent lookup before it leaves the block as a Q15 feature value with a valid strobe.

The frame geometry comes from the stream itself. A start-of-frame flag marks the first pixel and an end-of-line flag marks the last pixel of every row, so an image W wide and H high gives ((W-4)/2) by ((H-4)/2) results. Software writes the 36 taps and the bias through a small write port while the engine is quiet. Writes that arrive while pixels are flowing are dropped, so a frame is never computed with a mix of old and new weights.

Top module: `fcs_engine`

## Requirements
- R1: While reset is held, and after release until the first result, `feat_valid` is 0 and `feat_data` is 0.
- R2: For a frame W pixels wide (even, 6..MAX_W) and H rows high (even, 6..MAX_H), exactly ((W-4)/2)*((H-4)/2) results are produced, in raster order. Result (i,j) is computed from the window of pixel rows 2i..2i+5 and columns 2j..2j+5.
- R3: Tap address 6*a+b (a = row within the window counted from the top, b = column counted from the left, both 0..5) multiplies pixel (2i+a, 2j+b). The 36 Q30 products and the bias shifted left by 15 are summed in a 40-bit accumulator. The sum is rounded half-up to Q15 (add 2^14, then arithmetic shift right by 15).
- R4: The output equals T[s], where s is the signed value of bits 15:8 of the saturated pre-activation. For -128<s<127, T[s]=round-to-nearest(32767*tanh(3*(s+0.5)/128)). T[127]=0x7FFF and T[-128]=0x8001, so 0x8000 never appears.
- R5: A result becomes valid after the second rising edge following the edge that accepts the pixel completing its window.
- R6: Cycles with `pix_valid` low change nothing, whatever the other pixel inputs carry. Results do not depend on where such idle cycles fall.
- R7: In an idle cycle, a write with `cfg_addr` 0..35 sets that tap and a write with `cfg_addr` 36 sets the bias. Addresses 37..63 change nothing.
- R8: A write is dropped in any cycle where `pix_valid` is high or a result is still in the pipeline.
- R9: A pixel flagged start-of-frame restarts the position at row 0, column 0, even in the middle of a frame. Rows up to MAX_W (176) pixels wide are supported.
- R10: Pre-activation sums outside [-1, 1) saturate to 0x7FFF or 0x8000 before the lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pix_valid | input | 1 | Pixel present this cycle |
| pix_sof | input | 1 | Pixel is the first of a frame |
| pix_eol | input | 1 | Pixel is the last of its row |
| pix_data | input | 16 | Pixel value, Q15 |
| cfg_we | input | 1 | Weight write strobe |
| cfg_addr | input | 6 | 0..35 tap, 36 bias |
| cfg_data | input | 16 | Weight value, Q15 |
| feat_valid | output | 1 | Result valid |
| feat_data | output | 16 | Activated result, Q15 |

## Verification
Several weight sets are each run with a single tap at about 1.0 and all other taps at zero. Each of these results should equal one pixel, so a transposed, mirrored or off-by-one window shows up at once. Dense pseudo-random weights and images test the full accumulate and the rounding. The same frame is then streamed again with idle cycles full of junk flags, and with rejected weight writes mixed in, to confirm that the results do not change. Saturating frames of both signs reach the two end entries of the table. A full-width frame and a frame that is restarted partway through test the handling of position.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

   // exp() by power series, used only while building constant tables
   function automatic real series_exp(real x);
      real term;
      real acc;
      term = 1.0;
      acc  = 1.0;
      for (int k = 1; k < 48; k++) begin
         term = term * x / real'(k);
         acc  = acc + term;
      end
      return acc;
   endfunction

   // activation table entry for signed bin s
   function automatic int tanh_code(int s, int lut_bits, int data_w, int gain);
      int  half;
      int  full;
      real x;
      real e;
      real t;
      half = 1 << (lut_bits - 1);
      full = (1 << (data_w - 1)) - 1;
      if (s == half - 1) return full;
      if (s == -half) return -full;
      x = real'(gain) * (real'(s) + 0.5) / real'(half);
      if (x < 0.0) x = -x;
      e = series_exp(2.0 * x);
      t = (e - 1.0) / (e + 1.0);
      if (s < 0) t = -t;
      return int'(real'(full) * t);
   endfunction

endpackage

// File: rtl/fcs_window.sv
module fcs_window #(
   parameter int DATA_W = 16,
   parameter int KS     = 6,
   parameter int MAX_W  = 176,
   parameter int MAX_H  = 144
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       in_valid,
   input  logic                       in_sof,
   input  logic                       in_eol,
   input  logic [DATA_W-1:0]          in_data,
   output logic [KS*KS*DATA_W-1:0]    win_flat,
   output logic                       win_fire
);
   localparam int COL_W = $clog2(MAX_W);
   localparam int ROW_W = $clog2(MAX_H + 1);
   localparam bit PAR   = 1'((KS - 1) % 2);

   logic [COL_W-1:0]  col_q, col_cur;
   logic [ROW_W-1:0]  row_q, row_cur;
   logic [DATA_W-1:0] col_vec [KS];
   logic [DATA_W-1:0] win [KS][KS];

   assign col_cur = in_sof ? '0 : col_q;
   assign row_cur = in_sof ? '0 : row_q;
   assign col_vec[KS-1] = in_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         col_q    <= '0;
         row_q    <= '0;
         win_fire <= 1'b0;
      end else begin
         win_fire <= in_valid && (row_cur >= ROW_W'(KS - 1)) && (col_cur >= COL_W'(KS - 1))
                     && (row_cur[0] == PAR) && (col_cur[0] == PAR);
         if (in_valid) begin
            if (in_eol) begin
               col_q <= '0;
               row_q <= row_cur + 1'b1;
            end else begin
               col_q <= col_cur + 1'b1;
               row_q <= row_cur;
            end
         end
      end
   end

   // one row store per older window row; each shifts its column up a row
   for (genvar k = 0; k < KS - 1; k++) begin : g_row
      logic [DATA_W-1:0] mem [MAX_W];
      assign col_vec[k] = mem[col_cur];
      always_ff @(posedge clk) begin
         if (in_valid) mem[col_cur] <= col_vec[k+1];
      end
   end

   always_ff @(posedge clk) begin
      if (in_valid) begin
         for (int r = 0; r < KS; r++) begin
            for (int c = 0; c < KS - 1; c++) win[r][c] <= win[r][c+1];
            win[r][KS-1] <= col_vec[r];
         end
      end
   end

   for (genvar r = 0; r < KS; r++) begin : g_wr
      for (genvar c = 0; c < KS; c++) begin : g_wc
         assign win_flat[(r*KS+c)*DATA_W +: DATA_W] = win[r][c];
      end
   end
endmodule

// File: rtl/fcs_mac.sv
module fcs_mac #(
   parameter int DATA_W = 16,
   parameter int KS     = 6,
   parameter int ACC_W  = 40
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       in_fire,
   input  logic [KS*KS*DATA_W-1:0]    win_flat,
   input  logic [KS*KS*DATA_W-1:0]    coef_flat,
   input  logic [DATA_W-1:0]          bias,
   output logic                       pre_valid,
   output logic [DATA_W-1:0]          pre_data
);
   localparam int TAPS = KS * KS;
   localparam logic signed [ACC_W-1:0] HALF_LSB =
      {{(ACC_W-DATA_W+1){1'b0}}, 1'b1, {(DATA_W-2){1'b0}}};
   localparam logic signed [ACC_W-1:0] TOP_V =
      {{(ACC_W-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
   localparam logic signed [ACC_W-1:0] BOT_V =
      {{(ACC_W-DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};

   logic signed [ACC_W-1:0] prod [TAPS];
   logic signed [ACC_W-1:0] acc, rnd, shr;
   logic [DATA_W-1:0]       sat;

   for (genvar t = 0; t < TAPS; t++) begin : g_tap
      logic signed [2*DATA_W-1:0] p;
      assign p       = $signed(coef_flat[t*DATA_W +: DATA_W]) * $signed(win_flat[t*DATA_W +: DATA_W]);
      assign prod[t] = ACC_W'(p);
   end

   always_comb begin
      acc = ACC_W'($signed(bias)) <<< (DATA_W - 1);
      for (int t = 0; t < TAPS; t++) acc = acc + prod[t];
      rnd = acc + HALF_LSB;
      shr = rnd >>> (DATA_W - 1);
      if (shr > TOP_V)      sat = TOP_V[DATA_W-1:0];
      else if (shr < BOT_V) sat = BOT_V[DATA_W-1:0];
      else                  sat = shr[DATA_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_valid <= 1'b0;
         pre_data  <= '0;
      end else begin
         pre_valid <= in_fire;
         if (in_fire) pre_data <= sat;
      end
   end
endmodule

// File: rtl/fcs_act.sv
module fcs_act #(
   parameter int DATA_W   = 16,
   parameter int LUT_BITS = 8,
   parameter int ACT_GAIN = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   input  logic [LUT_BITS-1:0]  in_idx,
   output logic                 out_valid,
   output logic [DATA_W-1:0]    out_data
);
   localparam int ENTRIES = 1 << LUT_BITS;
   localparam int HALF    = ENTRIES / 2;

   logic [DATA_W-1:0] rom [ENTRIES];

   for (genvar g = 0; g < ENTRIES; g++) begin : g_rom
      localparam int SBIN = (g < HALF) ? g : g - ENTRIES;
      assign rom[g] = DATA_W'(fcs_pkg::tanh_code(SBIN, LUT_BITS, DATA_W, ACT_GAIN));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) out_data <= rom[in_idx];
      end
   end
endmodule

// File: rtl/fcs_engine.sv
module fcs_engine #(
   parameter int DATA_W   = 16,
   parameter int BASE_K   = 5,
   parameter int MAX_W    = 176,
   parameter int MAX_H    = 144,
   parameter int ACC_W    = 40,
   parameter int LUT_BITS = 8,
   parameter int ACT_GAIN = 3,
   localparam int KS      = BASE_K + 1,
   localparam int TAPS    = KS * KS,
   localparam int ADDR_W  = $clog2(TAPS + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               pix_valid,
   input  logic               pix_sof,
   input  logic               pix_eol,
   input  logic [DATA_W-1:0]  pix_data,
   input  logic               cfg_we,
   input  logic [ADDR_W-1:0]  cfg_addr,
   input  logic [DATA_W-1:0]  cfg_data,
   output logic               feat_valid,
   output logic [DATA_W-1:0]  feat_data
);
   if (ACC_W < 2*DATA_W + $clog2(TAPS) + 1) begin : g_bad_acc
      initial $fatal(1, "accumulator too narrow for tap count");
   end
   if (LUT_BITS > DATA_W || LUT_BITS < 2) begin : g_bad_lut
      initial $fatal(1, "lookup index width out of range");
   end
   if (MAX_W < KS || MAX_H < KS) begin : g_bad_dim
      initial $fatal(1, "image limits smaller than the window");
   end

   logic [TAPS*DATA_W-1:0] coef_q;
   logic [DATA_W-1:0]      bias_q;
   logic [TAPS*DATA_W-1:0] win_flat;
   logic                   win_fire;
   logic                   pre_valid;
   logic [DATA_W-1:0]      pre_data;
   logic                   busy;
   logic                   unused_pre_low;

   assign busy           = pix_valid | win_fire | pre_valid;
   assign unused_pre_low = ^pre_data[DATA_W-LUT_BITS-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         coef_q <= '0;
         bias_q <= '0;
      end else if (cfg_we && !busy) begin
         for (int t = 0; t < TAPS; t++)
            if (cfg_addr == ADDR_W'(t)) coef_q[t*DATA_W +: DATA_W] <= cfg_data;
         if (cfg_addr == ADDR_W'(TAPS)) bias_q <= cfg_data;
      end
   end

   fcs_window #(.DATA_W(DATA_W), .KS(KS), .MAX_W(MAX_W), .MAX_H(MAX_H)) i_window (
      .clk(clk), .rst_n(rst_n), .in_valid(pix_valid), .in_sof(pix_sof),
      .in_eol(pix_eol), .in_data(pix_data), .win_flat(win_flat), .win_fire(win_fire));

   fcs_mac #(.DATA_W(DATA_W), .KS(KS), .ACC_W(ACC_W)) i_mac (
      .clk(clk), .rst_n(rst_n), .in_fire(win_fire), .win_flat(win_flat),
      .coef_flat(coef_q), .bias(bias_q), .pre_valid(pre_valid), .pre_data(pre_data));

   fcs_act #(.DATA_W(DATA_W), .LUT_BITS(LUT_BITS), .ACT_GAIN(ACT_GAIN)) i_act (
      .clk(clk), .rst_n(rst_n), .in_valid(pre_valid),
      .in_idx(pre_data[DATA_W-1 -: LUT_BITS]),
      .out_valid(feat_valid), .out_data(feat_data));
endmodule

// File: rtl/fcs_engine_chk.sv
module fcs_engine_chk #(
   parameter int DATA_W = 16,
   parameter int TAPS   = 36
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   pix_valid,
   input logic                   cfg_we,
   input logic [TAPS*DATA_W-1:0] coef_q,
   input logic [DATA_W-1:0]      bias_q,
   input logic                   win_fire,
   input logic                   pre_valid,
   input logic [DATA_W-1:0]      pre_data,
   input logic                   feat_valid,
   input logic [DATA_W-1:0]      feat_data
);
   localparam logic [DATA_W-1:0] POS_MAX = {1'b0, {(DATA_W-1){1'b1}}};
   localparam logic [DATA_W-1:0] NEG_MIN = {1'b1, {(DATA_W-1){1'b0}}};
   localparam logic [DATA_W-1:0] NEG_SYM = {1'b1, {(DATA_W-2){1'b0}}, 1'b1};

   // R8
   cfg_drop_stream_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && pix_valid) |=> ($stable(coef_q) && $stable(bias_q)));

   // R8
   cfg_drop_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pre_valid || win_fire) |=> ($stable(coef_q) && $stable(bias_q)));

   // R5
   latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      feat_valid |-> $past(pix_valid, 3));

   // R5
   stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
      win_fire |=> pre_valid);

   // R2
   fire_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      win_fire |-> $past(pix_valid));

   // R4
   no_min_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      feat_valid |-> (feat_data != NEG_MIN));

   // R10
   pos_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pre_valid && pre_data == POS_MAX) |=> (feat_data == POS_MAX));

   // R10
   neg_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pre_valid && pre_data == NEG_MIN) |=> (feat_data == NEG_SYM));
endmodule

bind fcs_engine fcs_engine_chk #(.DATA_W(DATA_W), .TAPS(TAPS)) i_chk (
   .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .cfg_we(cfg_we),
   .coef_q(coef_q), .bias_q(bias_q), .win_fire(win_fire), .pre_valid(pre_valid),
   .pre_data(pre_data), .feat_valid(feat_valid), .feat_data(feat_data));

// File: tb/test_fcs_engine.sv
`timescale 1ns/1ps
module test_fcs_engine;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pix_valid = 1'b0, pix_sof = 1'b0, pix_eol = 1'b0;
   logic [15:0] pix_data = '0;
   logic        cfg_we = 1'b0;
   logic [5:0]  cfg_addr = '0;
   logic [15:0] cfg_data = '0;
   logic        feat_valid;
   logic [15:0] feat_data;

   int checks = 0, errors = 0;
   int cyc = 0, last_acc = 0, last_out = 0;
   int img [16][176];
   int cf [36];
   int bias_v;
   int expq [$];
   string cur_req = "R1";
   int unsigned lcg = 32'h1234_5678;

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   fcs_engine i_fcs_engine (
      .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_sof(pix_sof),
      .pix_eol(pix_eol), .pix_data(pix_data), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_data(cfg_data), .feat_valid(feat_valid), .feat_data(feat_data));

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int rnd(input int span);
      lcg = lcg * 32'd1103515245 + 32'd12345;
      return int'((lcg >> 8) % span) - span / 2;
   endfunction

   function automatic int table_val(input int s);
      if (s == 127) return 32767;
      if (s == -128) return -32767;
      return int'(32767.0 * $tanh(3.0 * (real'(s) + 0.5) / 128.0));
   endfunction

   function automatic int model(input int i, input int j);
      longint acc = longint'(bias_v) <<< 15;
      longint r;
      int sat;
      for (int a = 0; a < 6; a++)
         for (int b = 0; b < 6; b++)
            acc += longint'(cf[a*6+b]) * longint'(img[2*i+a][2*j+b]);
      r = (acc + 64'sd16384) >>> 15;
      if (r > 32767) sat = 32767;
      else if (r < -32768) sat = -32768;
      else sat = int'(r);
      return table_val(sat >>> 8);
   endfunction

   task automatic expect_frame(input int w, input int h);
      for (int i = 0; i < (h - 4) / 2; i++)
         for (int j = 0; j < (w - 4) / 2; j++)
            expq.push_back(model(i, j));
   endtask

   always @(negedge clk) begin
      if (rst_n && feat_valid) begin
         last_out = cyc;
         if (expq.size() == 0) check(1'b0, {cur_req, " unexpected result"}, $signed(feat_data), 0);
         else begin
            int e;
            e = expq.pop_front();
            check($signed(feat_data) == e, cur_req, $signed(feat_data), e);
         end
      end
   end

   task automatic load_weights();
      for (int a = 0; a < 37; a++) begin
         @(negedge clk);
         cfg_we = 1'b1; cfg_addr = 6'(a); cfg_data = 16'(a < 36 ? cf[a] : bias_v);
      end
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic drive_frame(input int w, input int h, input bit gaps, input bit noise);
      for (int r = 0; r < h; r++) begin
         for (int c = 0; c < w; c++) begin
            if (gaps && ((r * w + c) % 3 == 1)) begin
               @(negedge clk);
               pix_valid = 1'b0; pix_sof = 1'b1; pix_eol = 1'b1; pix_data = 16'h7777; cfg_we = 1'b0;
            end
            @(negedge clk);
            pix_valid = 1'b1; pix_sof = (r == 0 && c == 0); pix_eol = (c == w - 1);
            pix_data = 16'(img[r][c]);
            cfg_we = noise; cfg_addr = 6'((r * w + c) % 37); cfg_data = 16'h5A5A;
            last_acc = cyc + 1;
         end
      end
      @(negedge clk);
      pix_valid = 1'b0; pix_sof = 1'b0; pix_eol = 1'b0; cfg_we = 1'b0;
      repeat (6) @(negedge clk);
      check(expq.size() == 0, {cur_req, " result count"}, expq.size(), 0);
   endtask

   task automatic fill_ramp();
      for (int r = 0; r < 16; r++)
         for (int c = 0; c < 176; c++)
            img[r][c] = ((r * 37 + c * 11) % 256 - 128) * 256;
   endtask

   task automatic fill_random();
      for (int r = 0; r < 16; r++)
         for (int c = 0; c < 176; c++)
            img[r][c] = rnd(65536);
   endtask

   task automatic fill_const(input int v);
      for (int r = 0; r < 16; r++)
         for (int c = 0; c < 176; c++)
            img[r][c] = v;
   endtask

   task automatic t_reset();
      cur_req = "R1";
      repeat (3) @(negedge clk);
      check(feat_valid == 1'b0, "R1 valid in reset", feat_valid, 0);
      check(feat_data == 16'h0, "R1 data in reset", feat_data, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check(feat_valid == 1'b0 && feat_data == 16'h0, "R1 after release", feat_data, 0);
   endtask

   // R2 / R3: single tap of ~1.0 picks one pixel out of each window
   task automatic t_tap(input int a, input int b);
      cur_req = "R2 R3 tap select";
      fill_ramp();
      for (int k = 0; k < 36; k++) cf[k] = 0;
      cf[a*6+b] = 32767; bias_v = 0;
      load_weights();
      expect_frame(12, 10);
      drive_frame(12, 10, 1'b0, 1'b0);
      check(last_out - last_acc == 2, "R5 latency", last_out - last_acc, 2);
   endtask

   task automatic t_dense(input bit gaps);
      cur_req = gaps ? "R6 idle cycles" : "R3 R4 dense";
      expect_frame(14, 12);
      drive_frame(14, 12, gaps, 1'b0);
   endtask

   task automatic t_sat(input int pix, input int c, input int b);
      cur_req = "R10 R4 saturation";
      fill_const(pix);
      for (int k = 0; k < 36; k++) cf[k] = c;
      bias_v = b;
      load_weights();
      expect_frame(8, 8);
      drive_frame(8, 8, 1'b0, 1'b0);
   endtask

   task automatic t_cfg();
      cur_req = "R8 writes while streaming";
      expect_frame(12, 8);
      drive_frame(12, 8, 1'b1, 1'b1);
      cur_req = "R7 address above bias";
      @(negedge clk); cfg_we = 1'b1; cfg_addr = 6'd40; cfg_data = 16'h7FFF;
      @(negedge clk); cfg_we = 1'b1; cfg_addr = 6'd63; cfg_data = 16'h4000;
      @(negedge clk); cfg_we = 1'b0;
      expect_frame(12, 8);
      drive_frame(12, 8, 1'b0, 1'b0);
   endtask

   task automatic t_restart();
      cur_req = "R9 restart";
      fill_random();
      for (int r = 0; r < 3; r++)
         for (int c = 0; c < 9; c++) begin
            @(negedge clk);
            pix_valid = 1'b1; pix_sof = (r == 0 && c == 0); pix_eol = (c == 8);
            pix_data = 16'(rnd(65536));
         end
      expect_frame(10, 8);
      drive_frame(10, 8, 1'b0, 1'b0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      check(1'b0, "watchdog expired", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      t_reset();
      t_tap(0, 0);
      t_tap(5, 5);
      t_tap(2, 3);
      fill_random();
      for (int k = 0; k < 36; k++) cf[k] = rnd(1600);
      bias_v = rnd(16000);
      load_weights();
      t_dense(1'b0);
      t_dense(1'b1);
      t_cfg();
      cur_req = "R9 full width";
      expect_frame(176, 6);
      drive_frame(176, 6, 1'b0, 1'b0);
      t_restart();
      t_sat(32767, 900, 32767);
      t_sat(-32768, 900, -32768);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule